// File: doc/BRIEF.md
# Microprogrammed Accumulator Processor

This block is a small processor with one accumulator. Its data path is 16 bits wide and its addresses are 8 bits wide. It runs programs held in a 256-word, 16-bit memory that sits outside the block. That memory has a combinational read port, addressed by the block's address output, and a write port that commits on the clock edge when the write strobe is high. Every register transfer is driven by a control word. The control word is looked up from a constant microcode table, indexed by a control address register.

Each instruction takes four microcycles of fetch: address out, read, opcode capture and dispatch. After fetch, the opcode is added to a fixed table base, and the sequencer jumps there. Each table entry either finishes the instruction itself or jumps into a short microroutine. The instruction set is:

- data movement: load and store;
- arithmetic: add, subtract and multiply;
- logic: and, or and not;
- one-bit logical shifts;
- a jump taken on a strictly positive accumulator;
- halt.

Halt parks the sequencer on a microinstruction that loops to itself, and it raises a status output.

Top module: `acc_cpu`

## Requirements
- R1: While reset is low, `mem_we` and `halted` are 0 and `mem_addr` is 0. Reset clears the program counter, the accumulator and the control address, so the first fetch after reset reads address 0.
- R2: An instruction word holds its opcode in bits 15..8 and its operand address `a` in bits 7..0. The opcodes are 01 STORE, 02 LOAD, 03 ADD, 04 SUB, 05 JMPGZ, 06 AND, 07 OR, 08 NOT, 09 SHIFTR, 0A SHIFTL, 0B MPY and 0C HALT. The opcode picks its microroutine by being added to the control address base of the dispatch table.
- R3: LOAD a sets ACC to mem[a], whatever ACC held before. ADD a and SUB a compute ACC+mem[a] and ACC-mem[a], modulo 2^16.
- R4: AND a and OR a combine ACC bitwise with mem[a]. NOT replaces ACC with its bitwise complement and ignores its address field.
- R5: STORE a writes ACC to mem[a]. `mem_we` is high for exactly one cycle, and during that cycle `mem_wdata` equals ACC and ACC is left unchanged. No other instruction raises `mem_we`.
- R6: JMPGZ a loads a into the program counter when ACC, read as a signed two's-complement value, is greater than zero. When ACC is zero or negative, execution continues at the next word.
- R7: SHIFTR and SHIFTL move ACC one bit right or left as logical shifts. The vacated bit is filled with 0 and the bit shifted out is lost.
- R8: MPY a sets ACC to the low 16 bits of ACC×mem[a], both read as unsigned.
- R9: After HALT, `halted` goes to 1 and stays at 1 until reset. From then on `mem_addr` holds still and `mem_we` stays 0.
- R10: Undefined opcodes (00 and 0D to FF) change neither ACC nor memory. The program counter advances to the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 8 | Memory address, taken from the address register |
| mem_rdata | input | 16 | Combinational read data for `mem_addr` |
| mem_wdata | output | 16 | Write data, taken from the buffer register |
| mem_we | output | 1 | Write strobe; memory commits on the rising edge while it is high |
| halted | output | 1 | High while the sequencer sits on the halt microinstruction |

## Verification
Some properties are checked on every cycle:

- the write data equals the accumulator whenever the strobe is high;
- a positive-accumulator jump lands on the address field, and any other jump falls through by one;
- a dispatch lands inside the opcode table;
- the fetch address follows the program counter;
- once halted, the core never writes and never moves its address.

The arithmetic and logic results, the way LOAD clears a stale accumulator, the skipping of undefined opcodes and the full 1-to-100 summing loop that must leave 5050 are shown only by the bench's programs. The bench's scoreboard predicts every memory write in order and checks each one.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;
  parameter int DATA_W = 16;
  parameter int ADDR_W = 8;
  parameter int OP_W   = 8;
  parameter int CAR_W  = 8;

  localparam logic [OP_W-1:0] OP_STORE  = 8'h01;
  localparam logic [OP_W-1:0] OP_LOAD   = 8'h02;
  localparam logic [OP_W-1:0] OP_ADD    = 8'h03;
  localparam logic [OP_W-1:0] OP_SUB    = 8'h04;
  localparam logic [OP_W-1:0] OP_JMPGZ  = 8'h05;
  localparam logic [OP_W-1:0] OP_AND    = 8'h06;
  localparam logic [OP_W-1:0] OP_OR     = 8'h07;
  localparam logic [OP_W-1:0] OP_NOT    = 8'h08;
  localparam logic [OP_W-1:0] OP_SHR    = 8'h09;
  localparam logic [OP_W-1:0] OP_SHL    = 8'h0A;
  localparam logic [OP_W-1:0] OP_MPY    = 8'h0B;
  localparam logic [OP_W-1:0] OP_HALT   = 8'h0C;
  localparam logic [OP_W-1:0] OP_LAST   = OP_HALT;

  // microcode address map
  localparam logic [CAR_W-1:0] UA_FETCH = 8'h00;
  localparam logic [CAR_W-1:0] UA_DISP  = 8'h10;
  localparam logic [CAR_W-1:0] UA_LOAD  = 8'h20;
  localparam logic [CAR_W-1:0] UA_ADD   = 8'h24;
  localparam logic [CAR_W-1:0] UA_SUB   = 8'h28;
  localparam logic [CAR_W-1:0] UA_AND   = 8'h2C;
  localparam logic [CAR_W-1:0] UA_OR    = 8'h30;
  localparam logic [CAR_W-1:0] UA_MPY   = 8'h34;
  localparam logic [CAR_W-1:0] UA_STORE = 8'h38;

  typedef enum logic [3:0] {
    ALU_NONE = 4'h0, ALU_ADD = 4'h3, ALU_SUB = 4'h4, ALU_AND = 4'h6,
    ALU_OR   = 4'h7, ALU_NOT = 4'h8, ALU_SHR = 4'h9, ALU_SHL = 4'hA,
    ALU_MPY  = 4'hB
  } alu_op_e;

  typedef struct packed {
    logic              pc_inc;
    logic              pc_ld_gz;
    logic              acc_clr;
    alu_op_e           alu;
    logic              mem_rd;
    logic              mem_wr;
    logic              mar_from_mbr;
    logic              mar_from_pc;
    logic              mbr_from_acc;
    logic              ir_ld;
    logic              br_ld;
    logic              car_inc;
    logic              car_jmp;
    logic              car_disp;
    logic              car_clr;
    logic              halt;
    logic [CAR_W-1:0]  next;
  } uword_t;

  function automatic logic acc_positive(input logic [DATA_W-1:0] a);
    return !a[DATA_W-1] && (|a);
  endfunction

  function automatic logic [DATA_W-1:0] alu_eval(input alu_op_e op,
                                                 input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    logic [2*DATA_W-1:0] prod;
    prod = {{DATA_W{1'b0}}, a} * {{DATA_W{1'b0}}, b};
    case (op)
      ALU_ADD: return a + b;
      ALU_SUB: return a - b;
      ALU_AND: return a & b;
      ALU_OR:  return a | b;
      ALU_NOT: return ~a;
      ALU_SHR: return {1'b0, a[DATA_W-1:1]};
      ALU_SHL: return {a[DATA_W-2:0], 1'b0};
      ALU_MPY: return prod[DATA_W-1:0];
      default: return a;
    endcase
  endfunction
endpackage

// File: rtl/acc_cpu_ucode.sv
module acc_cpu_ucode
  import acc_cpu_pkg::*;
(
  input  logic [CAR_W-1:0] car,
  output uword_t           uw
);
  localparam logic [CAR_W-1:0] ONE = 1;
  localparam logic [CAR_W-1:0] TWO = 2;

  function automatic uword_t w_finish(input alu_op_e op);
    uword_t w = '0;
    w.alu = op; w.pc_inc = 1'b1; w.car_clr = 1'b1;
    return w;
  endfunction

  function automatic uword_t w_operand(input logic [CAR_W-1:0] target);
    uword_t w = '0;
    w.mar_from_mbr = 1'b1; w.car_jmp = 1'b1; w.next = target;
    return w;
  endfunction

  function automatic uword_t w_read();
    uword_t w = '0;
    w.mem_rd = 1'b1; w.car_inc = 1'b1;
    return w;
  endfunction

  function automatic uword_t w_latch_br();
    uword_t w = '0;
    w.br_ld = 1'b1; w.car_inc = 1'b1;
    return w;
  endfunction

  always_comb begin
    uw = '0;
    case (car)
      // fetch: address out, read word, capture opcode, dispatch
      UA_FETCH:       begin uw.mar_from_pc = 1'b1; uw.car_inc = 1'b1; end
      UA_FETCH + ONE: uw = w_read();
      UA_FETCH + TWO: begin uw.ir_ld = 1'b1; uw.car_inc = 1'b1; end
      UA_FETCH + 8'd3: uw.car_disp = 1'b1;
      // dispatch table at UA_DISP + opcode
      UA_DISP:        uw = w_finish(ALU_NONE);
      UA_DISP + CAR_W'(OP_STORE): begin
        uw = w_operand(UA_STORE); uw.mbr_from_acc = 1'b1;
      end
      UA_DISP + CAR_W'(OP_LOAD): begin
        uw = w_operand(UA_LOAD); uw.acc_clr = 1'b1;
      end
      UA_DISP + CAR_W'(OP_ADD):   uw = w_operand(UA_ADD);
      UA_DISP + CAR_W'(OP_SUB):   uw = w_operand(UA_SUB);
      UA_DISP + CAR_W'(OP_JMPGZ): begin uw.pc_ld_gz = 1'b1; uw.car_clr = 1'b1; end
      UA_DISP + CAR_W'(OP_AND):   uw = w_operand(UA_AND);
      UA_DISP + CAR_W'(OP_OR):    uw = w_operand(UA_OR);
      UA_DISP + CAR_W'(OP_NOT):   uw = w_finish(ALU_NOT);
      UA_DISP + CAR_W'(OP_SHR):   uw = w_finish(ALU_SHR);
      UA_DISP + CAR_W'(OP_SHL):   uw = w_finish(ALU_SHL);
      UA_DISP + CAR_W'(OP_MPY):   uw = w_operand(UA_MPY);
      UA_DISP + CAR_W'(OP_HALT): begin
        uw.halt = 1'b1; uw.car_jmp = 1'b1; uw.next = UA_DISP + CAR_W'(OP_HALT);
      end
      // memory-operand routines: read, latch BR, operate
      UA_LOAD:        uw = w_read();
      UA_LOAD + ONE:  uw = w_latch_br();
      UA_LOAD + TWO:  uw = w_finish(ALU_ADD);
      UA_ADD:         uw = w_read();
      UA_ADD + ONE:   uw = w_latch_br();
      UA_ADD + TWO:   uw = w_finish(ALU_ADD);
      UA_SUB:         uw = w_read();
      UA_SUB + ONE:   uw = w_latch_br();
      UA_SUB + TWO:   uw = w_finish(ALU_SUB);
      UA_AND:         uw = w_read();
      UA_AND + ONE:   uw = w_latch_br();
      UA_AND + TWO:   uw = w_finish(ALU_AND);
      UA_OR:          uw = w_read();
      UA_OR + ONE:    uw = w_latch_br();
      UA_OR + TWO:    uw = w_finish(ALU_OR);
      UA_MPY:         uw = w_read();
      UA_MPY + ONE:   uw = w_latch_br();
      UA_MPY + TWO:   uw = w_finish(ALU_MPY);
      UA_STORE: begin uw.mem_wr = 1'b1; uw.pc_inc = 1'b1; uw.car_clr = 1'b1; end
      default:        uw.car_clr = 1'b1;
    endcase
  end
endmodule

// File: rtl/acc_cpu_seq.sv
module acc_cpu_seq
  import acc_cpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  uword_t           uw,
  input  logic [OP_W-1:0]  ir,
  output logic [CAR_W-1:0] car
);
  logic             op_undefined;
  logic [CAR_W-1:0] disp_tgt;

  assign op_undefined = (ir == '0) || (ir > OP_LAST);
  assign disp_tgt     = op_undefined ? UA_DISP : UA_DISP + CAR_W'(ir);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           car <= UA_FETCH;
    else if (uw.car_clr)  car <= UA_FETCH;
    else if (uw.car_disp) car <= disp_tgt;
    else if (uw.car_jmp)  car <= uw.next;
    else if (uw.car_inc)  car <= car + 1'b1;
  end

  // R9: the halt word keeps the control address fixed
  p_halt_loops_r9: assert property (@(posedge clk) disable iff (!rst_n)
    uw.halt |=> car == $past(car));
  // R2: a dispatch always lands inside the opcode table
  p_dispatch_in_table_r2: assert property (@(posedge clk) disable iff (!rst_n)
    uw.car_disp |=> (car >= UA_DISP) && (car <= UA_DISP + CAR_W'(OP_LAST)));
  // R10: an undefined opcode lands on the skip entry
  p_undef_to_skip_r10: assert property (@(posedge clk) disable iff (!rst_n)
    uw.car_disp && op_undefined |=> car == UA_DISP);
endmodule

// File: rtl/acc_cpu_dp.sv
module acc_cpu_dp
  import acc_cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  uword_t            uw,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [ADDR_W-1:0] mar,
  output logic [DATA_W-1:0] mbr,
  output logic [OP_W-1:0]   ir
);
  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] br, acc;
  logic              acc_pos;
  logic [ADDR_W-1:0] addr_field;

  assign acc_pos    = acc_positive(acc);
  assign addr_field = mbr[ADDR_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc <= '0; mar <= '0; mbr <= '0; ir <= '0; br <= '0; acc <= '0;
    end else begin
      if (uw.mar_from_pc)       mar <= pc;
      else if (uw.mar_from_mbr) mar <= addr_field;

      if (uw.mem_rd)            mbr <= mem_rdata;
      else if (uw.mbr_from_acc) mbr <= acc;

      if (uw.ir_ld) ir <= mbr[DATA_W-1 -: OP_W];
      if (uw.br_ld) br <= mbr;

      if (uw.acc_clr)               acc <= '0;
      else if (uw.alu != ALU_NONE)  acc <= alu_eval(uw.alu, acc, br);

      if (uw.pc_ld_gz)    pc <= acc_pos ? addr_field : pc + 1'b1;
      else if (uw.pc_inc) pc <= pc + 1'b1;
    end
  end

  // R5: write data is the accumulator, which the write leaves untouched
  p_store_data_r5: assert property (@(posedge clk) disable iff (!rst_n)
    uw.mem_wr |-> mbr == acc);
  p_store_keeps_acc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    uw.mem_wr |=> $stable(acc));
  // R6: taken and not-taken conditional jump
  p_jump_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
    uw.pc_ld_gz && acc_pos |=> pc == $past(addr_field));
  p_jump_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    uw.pc_ld_gz && !acc_pos |=> pc == $past(pc) + 1'b1);
  // R1: the fetch address follows the program counter
  p_fetch_addr_r1: assert property (@(posedge clk) disable iff (!rst_n)
    uw.mar_from_pc |=> mar == $past(pc));
endmodule

// File: rtl/acc_cpu.sv
module acc_cpu
  import acc_cpu_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  output logic              halted
);
  uword_t           uw;
  logic [CAR_W-1:0] car;
  logic [OP_W-1:0]  ir;

  acc_cpu_ucode u_ucode (.car(car), .uw(uw));

  acc_cpu_seq u_seq (
    .clk(clk), .rst_n(rst_n), .uw(uw), .ir(ir), .car(car)
  );

  acc_cpu_dp u_dp (
    .clk(clk), .rst_n(rst_n), .uw(uw), .mem_rdata(mem_rdata),
    .mar(mem_addr), .mbr(mem_wdata), .ir(ir)
  );

  assign mem_we = uw.mem_wr;
  assign halted = uw.halt;

  // R9: a halted core stays quiet on the memory bus
  p_halt_no_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_we);
  p_halt_addr_still_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted && $past(halted) |-> $stable(mem_addr));
  p_halt_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);
endmodule

// File: tb/tb_acc_cpu.sv
module tb_acc_cpu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  mem_addr;
  logic [15:0] mem_rdata, mem_wdata;
  logic        mem_we, halted;
  logic [15:0] mem [0:255];

  int checks = 0;
  int errs = 0;
  int cyc = 0;
  int wr_count = 0;

  logic [7:0]  exp_addr[$];
  logic [15:0] exp_data[$];
  string       exp_tag[$];

  logic [7:0]  asm_pc;
  logic [15:0] mdl;

  always #4 clk = ~clk;

  acc_cpu dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .halted(halted)
  );

  assign mem_rdata = mem[mem_addr];
  always @(posedge clk) if (mem_we) mem[mem_addr] <= mem_wdata;

  task automatic chk(input logic ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // scoreboard monitor: every write must match the next expected item
  always @(negedge clk) begin
    if (rst_n && mem_we) begin
      wr_count++;
      if (exp_addr.size() == 0) begin
        chk(1'b0, "R5", "unexpected write", {8'h0, mem_addr, mem_wdata}, 32'h0);
      end else begin
        chk(mem_addr == exp_addr[0] && mem_wdata == exp_data[0], exp_tag[0],
            "write addr/data", {8'h0, mem_addr, mem_wdata},
            {8'h0, exp_addr[0], exp_data[0]});
        void'(exp_addr.pop_front());
        void'(exp_data.pop_front());
        void'(exp_tag.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  // driver: assemble the program while predicting the accumulator
  task automatic clear_mem();
    for (int i = 0; i < 256; i++) mem[i] = 16'h0;
    asm_pc = 8'h00; mdl = 16'h0;
  endtask
  task automatic emit(input logic [7:0] op, input logic [7:0] a);
    mem[asm_pc] = {op, a}; asm_pc = asm_pc + 8'd1;
  endtask
  task automatic push(input logic [7:0] a, input logic [15:0] d, input string tag);
    exp_addr.push_back(a); exp_data.push_back(d); exp_tag.push_back(tag);
  endtask
  task automatic i_load(input logic [7:0] a);  emit(8'h02, a); mdl = mem[a]; endtask
  task automatic i_add(input logic [7:0] a);   emit(8'h03, a); mdl = mdl + mem[a]; endtask
  task automatic i_sub(input logic [7:0] a);   emit(8'h04, a); mdl = mdl - mem[a]; endtask
  task automatic i_and(input logic [7:0] a);   emit(8'h06, a); mdl = mdl & mem[a]; endtask
  task automatic i_or(input logic [7:0] a);    emit(8'h07, a); mdl = mdl | mem[a]; endtask
  task automatic i_not();  emit(8'h08, 8'h5A); mdl = 16'hFFFF ^ mdl; endtask
  task automatic i_shr();  emit(8'h09, 8'h00); mdl = mdl / 16'd2; endtask
  task automatic i_shl();  emit(8'h0A, 8'h00); mdl = {mdl[14:0], 1'b0}; endtask
  task automatic i_mpy(input logic [7:0] a);
    logic [31:0] p;
    emit(8'h0B, a);
    p = 32'(mdl) * 32'(mem[a]);
    mdl = p[15:0];
  endtask
  task automatic i_store(input logic [7:0] a, input string tag);
    emit(8'h01, a); push(a, mdl, tag);
  endtask

  task automatic run(input int limit, input string name);
    logic [7:0] hold_addr;
    int n, w0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!mem_we && !halted && mem_addr == 8'h00, "R1", {name, " reset outputs"},
        {30'h0, mem_we, halted}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(mem_addr == 8'h00, "R1", {name, " first fetch address"}, mem_addr, 0);
    n = 0;
    while (!halted && n < limit) begin @(negedge clk); n++; end
    chk(halted, "R9", {name, " halted reached"}, halted, 1);
    chk(exp_addr.size() == 0, "R5", {name, " all expected writes seen"},
        exp_addr.size(), 0);
    hold_addr = mem_addr; w0 = wr_count;
    repeat (12) @(negedge clk);
    chk(halted && mem_addr == hold_addr && wr_count == w0, "R9",
        {name, " stays halted and quiet"}, {mem_addr, 7'h0, halted},
        {hold_addr, 8'h01});
  endtask

  initial begin
    // program 1: arithmetic, logic, shifts, multiply, undefined opcodes
    clear_mem();
    mem[8'h80] = 16'h1234; mem[8'h81] = 16'h0F0F; mem[8'h82] = 16'hFFFF;
    mem[8'h83] = 16'h8001; mem[8'h84] = 16'h0003;
    i_load(8'h80); i_add(8'h81); i_store(8'h90, "R2/R3 add");
    i_sub(8'h82);  i_store(8'h91, "R3 sub wrap");
    i_and(8'h81);  i_store(8'h92, "R4 and");
    i_or(8'h83);   i_store(8'h93, "R4 or");
    i_shr();       i_store(8'h94, "R7 shr");
    i_load(8'h83); i_shl(); i_store(8'h95, "R7 shl drop msb");
    i_load(8'h83); i_shr(); i_store(8'h96, "R7 shr zero fill");
    i_not();       i_store(8'h97, "R4 not");
    i_load(8'h80); i_mpy(8'h84); i_store(8'h98, "R8 mpy");
    i_load(8'h82); i_mpy(8'h82); i_store(8'h99, "R8 mpy low half");
    i_load(8'h82); i_add(8'h83); i_store(8'h9A, "R3 add overflow");
    i_load(8'h84); emit(8'h0D, 8'h55); emit(8'h00, 8'h77); emit(8'hFF, 8'h80);
    i_store(8'h9B, "R10 undefined skipped");
    emit(8'h0C, 8'h00);
    run(20000, "prog1");
    chk(mem[8'h80] == 16'h1234 && mem[8'h55] == 16'h0000, "R10",
        "no stray memory change", {mem[8'h80], mem[8'h55]}, 32'h12340000);

    // program 2: jump conditions (negative, zero, positive)
    clear_mem();
    mem[8'h82] = 16'hFFFF; mem[8'h86] = 16'h0000; mem[8'h87] = 16'h7FFF;
    emit(8'h02, 8'h82); emit(8'h05, 8'h30); emit(8'h01, 8'h90);
    push(8'h90, 16'hFFFF, "R6 negative falls through");
    emit(8'h02, 8'h86); emit(8'h05, 8'h30); emit(8'h01, 8'h91);
    push(8'h91, 16'h0000, "R6 zero falls through");
    emit(8'h02, 8'h87); emit(8'h05, 8'h10); emit(8'h01, 8'h92); emit(8'h0C, 8'h00);
    mem[8'h10] = 16'h0193; mem[8'h11] = 16'h0C00;
    push(8'h93, 16'h7FFF, "R6 positive jumps");
    mem[8'h30] = 16'h019F; mem[8'h31] = 16'h0C00;
    run(20000, "prog2");

    // program 3: sum of 1..100 with a countdown loop
    clear_mem();
    mem[8'hA0] = 16'd0; mem[8'hA1] = 16'd1; mem[8'hA2] = 16'd100;
    emit(8'h02, 8'hA0); emit(8'h01, 8'hA4); emit(8'h02, 8'hA2); emit(8'h01, 8'hA3);
    emit(8'h02, 8'hA4); emit(8'h03, 8'hA3); emit(8'h01, 8'hA4);
    emit(8'h02, 8'hA3); emit(8'h04, 8'hA1); emit(8'h01, 8'hA3);
    emit(8'h05, 8'h04); emit(8'h0C, 8'h00);
    push(8'hA4, 16'd0, "R5 sum init"); push(8'hA3, 16'd100, "R5 temp init");
    begin
      int s = 0;
      for (int t = 100; t >= 1; t--) begin
        s = s + t;
        push(8'hA4, 16'(s), "R3 loop sum");
        push(8'hA3, 16'(t - 1), "R6 loop temp");
      end
    end
    run(40000, "prog3");
    chk(mem[8'hA4] == 16'd5050, "R3", "final sum", mem[8'hA4], 5050);
    chk(mem[8'hA3] == 16'd0, "R6", "final counter", mem[8'hA3], 0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule